// File: doc/BRIEF.md
# Packet Boundary Preserving Wrapper

This block places a processing core that understands only payload, valid and ready inside a packetized stream. The end-of-packet flag is removed before the core. The wrapper counts the words of every input packet. When a packet closes, it stores the packet's word count in a shallow side queue. On the far side of the core it counts the words that leave. It raises the end-of-packet flag again on the word whose position matches the length at the head of the queue, and then retires that entry.

The core must keep word order and must neither drop nor add words. For verification it is modelled by a plain synchronous FIFO of configurable depth. The core sits outside the wrapper and connects through two plain valid/ready ports. A 32-bit counter records boundary faults. One fault is a packet longer than the length field can hold. The other is an output word for which no boundary information exists.

Top module: `pkt_boundary_wrapper`

## Requirements
- R1: The core input carries only payload and valid. `core_in_data` equals `in_data`, and `core_in_valid` equals `in_valid` whenever the side queue is not full.
- R2: When an input word with `in_last` high is accepted, the packet's word count, including that word, is stored in the side queue. The input count then restarts at zero.
- R3: The side queue holds `LEN_DEPTH` lengths (3 by default). While it is full, `in_ready` and `core_in_valid` are both low, so no boundary is lost.
- R4: Output words pass through unchanged. `out_last` is high on the word whose 1-based position in its packet equals the length at the head of the side queue, and that entry is retired when the word is accepted.
- R5: While the side queue is empty, output words that belong to the input packet still being received pass through with `out_last` low. These words leave the error count unchanged.
- R6: An input word accepted when the packet's count already equals 2^LEN_W-1 (1023 by default) adds one to `err_count`. The count saturates at that value, and the saturated value is what gets stored.
- R7: An output word accepted while the side queue is empty, with no unsent words of the open input packet, adds one to `err_count` and carries `out_last` low.
- R8: Packets of 1, 12, 24 and 1000 words sent back to back through a 200-deep core come out with identical data, and each has exactly one `out_last`, on its final word.
- R9: After reset, `err_count` is 0, `out_last` is 0, and `in_ready` follows `core_in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Packetized input payload |
| in_valid | input | 1 | Input word present |
| in_last | input | 1 | Input word closes its packet |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| core_in_data | output | DATA_W | Payload toward the core |
| core_in_valid | output | 1 | Word toward the core present |
| core_in_ready | input | 1 | Core can take a word |
| core_out_data | input | DATA_W | Payload from the core |
| core_out_valid | input | 1 | Word from the core present |
| core_out_ready | output | 1 | Wrapper takes the core's word |
| out_data | output | DATA_W | Packetized output payload |
| out_valid | output | 1 | Output word present |
| out_last | output | 1 | Output word closes its packet |
| out_ready | input | 1 | Downstream takes the output word |
| err_count | output | ERR_W | Count of boundary faults |

## Verification
The handshake ports, `out_last` and the core-side signals are combinational in the same cycle as the words they describe. The bench therefore changes its drives on the falling edge, waits 1 ns, and reads the handshake that the next rising edge will complete. A stored length and a retired entry take effect from the rising edge that accepts the word. An increment of `err_count` is visible from the edge that accepts the offending word. The overflow check therefore reads the counter one half-cycle after the final input word is accepted, which is before that word can leave a core with one cycle of latency. The orphan increment is checked only once the core has drained.

// File: rtl/pbw_pkg.sv
// Package: shared default sizes for the packet boundary wrapper.
// Assumes: nothing; holds constants only.
package pbw_pkg;
    localparam int PBW_DATA_W    = 32;
    localparam int PBW_LEN_W     = 10;
    localparam int PBW_LEN_DEPTH = 3;
    localparam int PBW_ERR_W     = 32;
endpackage

// File: rtl/pbw_len_fifo.sv
// Module: shallow queue of packet lengths.
// Assumes: push is never issued when full and pop never when empty
// (the wrapper gates both); depth need not be a power of two.
module pbw_len_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_len,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;

    // Store the incoming length in the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) slot[wp] <= push_len;
    end

    // Advance the pointers with wrap at DEPTH and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    assign head  = slot[rp];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign level = fill;

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push); // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop); // R4
endmodule

// File: rtl/pbw_in_tracker.sv
// Module: counts words of the packet being received and emits its length.
// Assumes: beat is a completed input handshake; counts saturate at 2^LW-1.
module pbw_in_tracker #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          beat_last,
    output logic          len_push,
    output logic [LW-1:0] len_val,
    output logic          ovf_err,
    output logic [LW-1:0] open_cnt
);
    localparam logic [LW-1:0] CNT_MAX = {LW{1'b1}};

    logic [LW-1:0] cnt;
    logic          at_max;

    // Flag saturation and form the length to store for a closing word.
    always_comb begin
        at_max   = (cnt == CNT_MAX);
        ovf_err  = beat & at_max;
        len_push = beat & beat_last;
        len_val  = at_max ? cnt : cnt + LW'(1);
    end

    // Count accepted words; restart after a closing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (beat) begin
            if (beat_last)    cnt <= '0;
            else if (!at_max) cnt <= cnt + LW'(1);
        end
    end

    assign open_cnt = cnt;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (beat && beat_last) |=> (open_cnt == '0)); // R2
endmodule

// File: rtl/pbw_out_marker.sv
// Module: counts words leaving the core and marks the closing word.
// Assumes: the core keeps order and neither drops nor adds words.
module pbw_out_marker #(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic [LW-1:0] head,
    input  logic          empty,
    input  logic [LW-1:0] open_cnt,
    output logic          is_last,
    output logic          pop,
    output logic          orphan_err
);
    logic [LW-1:0] ocnt;
    logic [LW:0]   pos;
    logic          pending;

    // Compare the next word position with the head length.
    always_comb begin
        pos        = {1'b0, ocnt} + (LW+1)'(1);
        is_last    = !empty && (pos == {1'b0, head});
        pop        = beat & is_last;
        pending    = (ocnt < open_cnt);
        orphan_err = beat & empty & !pending;
    end

    // Advance the output position; restart after a marked word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocnt <= '0;
        end else if (beat) begin
            if (is_last)          ocnt <= '0;
            else if (!orphan_err) ocnt <= ocnt + LW'(1);
        end
    end

    AST_ORPHAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) orphan_err |=> $stable(ocnt)); // R7
endmodule

// File: rtl/pbw_core_fifo.sv
// Module: plain synchronous FIFO standing in for the processing core.
// Assumes: single clock; data visible one cycle after it is written.
module pbw_core_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          wr, rd;

    assign in_ready  = (fill != CW'(DEPTH));
    assign out_valid = (fill != '0);
    assign out_data  = mem[rp];
    assign wr        = in_valid & in_ready;
    assign rd        = out_valid & out_ready;

    // Write the accepted word into storage.
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= in_data;
    end

    // Move pointers and keep the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            fill <= fill + CW'(wr) - CW'(rd);
        end
    end
endmodule

// File: rtl/pkt_boundary_wrapper.sv
// Module: keeps packet boundaries across a core with no end-of-packet flag.
// Assumes: the core preserves order and word count; one clock domain.
module pkt_boundary_wrapper
    import pbw_pkg::*;
#(
    parameter int DATA_W    = PBW_DATA_W,
    parameter int LEN_W     = PBW_LEN_W,
    parameter int LEN_DEPTH = PBW_LEN_DEPTH,
    parameter int ERR_W     = PBW_ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] core_in_data,
    output logic              core_in_valid,
    input  logic              core_in_ready,
    input  logic [DATA_W-1:0] core_out_data,
    input  logic              core_out_valid,
    output logic              core_out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic [ERR_W-1:0]  err_count
);
    localparam int CW = $clog2(LEN_DEPTH + 1);

    logic             q_full, q_empty, q_push, q_pop;
    logic [LEN_W-1:0] q_head, q_len, open_cnt;
    logic [CW-1:0]    q_level;
    logic             in_fire, out_fire, ovf_err, orphan_err, mark;

    // Input side: strip the flag and stall while the length queue is full.
    always_comb begin
        core_in_data  = in_data;
        core_in_valid = in_valid & ~q_full;
        in_ready      = core_in_ready & ~q_full;
        in_fire       = in_valid & in_ready;
    end

    // Output side: pass the core's words through and add the flag back.
    always_comb begin
        out_data       = core_out_data;
        out_valid      = core_out_valid;
        core_out_ready = out_ready;
        out_fire       = core_out_valid & out_ready;
        out_last       = core_out_valid & mark;
    end

    pbw_in_tracker #(.LW(LEN_W)) u_in_tracker (
        .clk(clk), .rst_n(rst_n), .beat(in_fire), .beat_last(in_last),
        .len_push(q_push), .len_val(q_len), .ovf_err(ovf_err), .open_cnt(open_cnt)
    );

    pbw_len_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_len_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_len(q_len), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full), .level(q_level)
    );

    pbw_out_marker #(.LW(LEN_W)) u_out_marker (
        .clk(clk), .rst_n(rst_n), .beat(out_fire), .head(q_head), .empty(q_empty),
        .open_cnt(open_cnt), .is_last(mark), .pop(q_pop), .orphan_err(orphan_err)
    );

    // Accumulate both fault kinds; both may occur in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_count <= '0;
        else        err_count <= err_count + ERR_W'(ovf_err) + ERR_W'(orphan_err);
    end

    AST_LAST_POPS: assert property (@(posedge clk) disable iff (!rst_n) (out_fire && out_last && !q_push) |=> (q_level == $past(q_level) - CW'(1))); // R4
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((err_count - $past(err_count)) <= ERR_W'(2))); // R6
endmodule

// File: tb/pkt_boundary_wrapper_bench.sv
module pkt_boundary_wrapper_bench;
    localparam int DW = 32;
    localparam int MAXLEN = 1023;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] in_data = '0, core_in_data, core_out_data, out_data;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic core_in_valid, core_in_ready, core_out_valid, core_out_ready;
    logic out_valid, out_last, out_ready = 1'b0;
    logic [31:0] err_count;

    always #5 clk = ~clk;

    pkt_boundary_wrapper u_pkt_boundary_wrapper (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .core_in_data(core_in_data),
        .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
        .core_out_data(core_out_data), .core_out_valid(core_out_valid),
        .core_out_ready(core_out_ready), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .out_ready(out_ready), .err_count(err_count)
    );

    pbw_core_fifo #(.DW(DW), .DEPTH(200)) u_core (
        .clk(clk), .rst_n(rst_n), .in_data(core_in_data), .in_valid(core_in_valid),
        .in_ready(core_in_ready), .out_data(core_out_data), .out_valid(core_out_valid),
        .out_ready(core_out_ready)
    );

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_d [8192];
    bit            exp_l [8192];
    int wr_idx = 0, rd_idx = 0;
    bit hold_rdy = 1'b1, finished = 1'b0, monitor_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected closing flag: the last word, or word MAXLEN for a saturated packet.
    function automatic bit exp_flag(input int w, input int len);
        if (len > MAXLEN) return (w == MAXLEN - 1);
        return (w == len - 1);
    endfunction

    task automatic send_pkt(input int len, input bit gaps);
        for (int w = 0; w < len; w++) begin
            logic [DW-1:0] d;
            @(negedge clk);
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                repeat (1 + $urandom % 2) @(negedge clk);
            end
            d = $urandom;
            in_valid = 1'b1; in_data = d; in_last = (w == len - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            exp_d[wr_idx] = d; exp_l[wr_idx] = exp_flag(w, len); wr_idx++;
        end
    endtask

    task automatic idle_in();
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (rd_idx != wr_idx && t < 20000) begin @(negedge clk); t++; end
        chk(rd_idx == wr_idx, "R4", "drained word count", 64'(rd_idx), 64'(wr_idx));
    endtask

    // Output monitor: R2,R4 each accepted word matches data and closing flag.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = hold_rdy ? 1'b0 : (($urandom % 4) != 0);
            #1;
            if (monitor_on && out_valid && out_ready) begin
                if (rd_idx >= wr_idx) begin
                    chk(1'b0, "R4", "unexpected output word", 64'(rd_idx), 64'(wr_idx));
                end else begin
                    chk(out_data == exp_d[rd_idx], "R4", "data", 64'(out_data), 64'(exp_d[rd_idx]));
                    chk(out_last == exp_l[rd_idx], "R2", "out_last", 64'(out_last), 64'(exp_l[rd_idx]));
                end
                rd_idx++;
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int big_start;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(err_count == 0, "R9", "err_count", 64'(err_count), 64'd0);
        chk(out_last == 1'b0, "R9", "out_last", 64'(out_last), 64'd0);
        chk(in_ready == core_in_ready, "R9", "in_ready", 64'(in_ready), 64'(core_in_ready));
        monitor_on = 1'b1; hold_rdy = 1'b0;

        // R1 core side mirrors the input
        @(negedge clk); in_valid = 1'b1; in_data = 32'hA5A5_0001; in_last = 1'b1; #1;
        chk(core_in_valid == 1'b1, "R1", "core_in_valid", 64'(core_in_valid), 64'd1);
        chk(core_in_data == in_data, "R1", "core_in_data", 64'(core_in_data), 64'(in_data));
        exp_d[wr_idx] = in_data; exp_l[wr_idx] = 1'b1; wr_idx++;
        idle_in();
        drain();

        // R8 back-to-back packets; R5 early words of the long packet
        send_pkt(1, 1'b0); send_pkt(12, 1'b0); send_pkt(24, 1'b0);
        big_start = wr_idx;
        send_pkt(1000, 1'b0);
        chk(rd_idx > big_start, "R5", "words out before length known", 64'(rd_idx), 64'(big_start + 1));
        idle_in();
        drain();
        chk(err_count == 0, "R5", "err_count after open-packet output", 64'(err_count), 64'd0);
        chk(err_count == 0, "R8", "no fault on 1/12/24/1000", 64'(err_count), 64'd0);

        // Random packet lengths and gaps
        for (int p = 0; p < 30; p++) send_pkt(1 + $urandom % 20, 1'b1);
        idle_in();
        drain();
        chk(err_count == 0, "R4", "err_count after random packets", 64'(err_count), 64'd0);

        // R3 stall while three lengths are queued
        hold_rdy = 1'b1;
        repeat (2) @(negedge clk);
        send_pkt(2, 1'b0); send_pkt(1, 1'b0); send_pkt(3, 1'b0);
        @(negedge clk); in_valid = 1'b1; in_data = 32'hC0DE_0003; in_last = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(in_ready == 1'b0, "R3", "in_ready while full", 64'(in_ready), 64'd0);
            chk(core_in_valid == 1'b0, "R3", "core_in_valid while full", 64'(core_in_valid), 64'd0);
            @(negedge clk);
        end
        hold_rdy = 1'b0;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        exp_d[wr_idx] = in_data; exp_l[wr_idx] = 1'b1; wr_idx++;
        idle_in();
        drain();

        // R6 overflow packet, R7 its trailing orphan word
        send_pkt(MAXLEN + 1, 1'b0);
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; #1;
        chk(err_count == 1, "R6", "err_count after saturated packet", 64'(err_count), 64'd1);
        drain();
        chk(err_count == 2, "R7", "err_count after orphan word", 64'(err_count), 64'd2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule